// File: doc/BRIEF.md
# Threshold-Compare Timer Bank

The block holds a bank of independent event timers behind one word-addressed register port. Each timer counts edges of its own external clock input. The input is brought into the system clock domain through a two-stage synchroniser and an edge detector. A per-timer control bit selects which edge of the input is counted. When the count reaches the timer's programmed threshold, the timer raises an interrupt, returns its count to zero and either keeps running (cyclic) or stops itself (one-shot).

Each timer's interrupt output takes one of two forms. It can be a one-cycle pulse per threshold hit, or it can be a level that follows a sticky status bit until software clears it. Software may rewrite the threshold while the timer is running, and the new value applies to the count already in progress. The count can be read at any moment, and reading it does not disturb it.

Top module: `tmr_bank`

## Requirements
- R1: After reset every timer reads control 0, threshold 0xFFFF, count 0 and status 0, and every irq_o bit is low.
- R2: Word address is {timer index, 2-bit register select}. Select 0 is control, with bit0 run, bit1 one-shot, bit2 invert input and bit3 level interrupt. Select 1 is the threshold (bits 15:0). Select 2 is the count (read only, bits 15:0). Select 3 is status (bit0). Read data is combinational from the address, and unused bits read 0.
- R3: A running timer adds one to its count for each active edge of its input. The count updates on the third system clock edge after the input changes.
- R4: With control bit2 clear the timer counts rising input edges. With bit2 set it counts falling edges, and a rising edge alone leaves the count unchanged.
- R5: When count+1 is greater than or equal to the threshold on an active edge, that edge is a hit. The count becomes 0 and status bit0 is set. In cyclic mode the run bit stays 1 and counting continues.
- R6: In one-shot mode a hit clears the run bit, and later input edges leave the count at 0.
- R7: With control bit3 clear, irq_o for the timer is high for exactly one system clock per hit and low otherwise, even while status is set.
- R8: With control bit3 set, irq_o follows status bit0. The output stays high until a write of 1 to status bit0, and a write of 0 there changes nothing.
- R9: If a hit and a status clear write occur in the same cycle, status stays set.
- R10: A threshold written while the timer runs applies to the current count. A new value at or below count+1 causes a hit on the next active edge.
- R11: Clearing the run bit holds the count at its value. Repeated count reads return the same value and do not change it.
- R12: Edges and register writes for one timer leave every other timer's count and status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_clk_i | input | N_TMR | Per-timer external count inputs, asynchronous |
| bus_wr_i | input | 1 | Write strobe for the register port |
| bus_addr_i | input | IDX_W+2 | Word address: timer index and register select |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for the addressed register |
| irq_o | output | N_TMR | Per-timer interrupt outputs |

## Verification
Several rules are checked by assertions on every cycle. A pulse interrupt never lasts two cycles. A level status holds until it is cleared, and a hit always leaves status set, even against a clear. A hit zeroes the count, a one-shot hit drops the run bit, a stopped timer's count does not move, and each counted edge adds exactly one. The remaining behaviour can only be shown by the bench scenarios. These cover the three-cycle input latency, counting on the falling edge under inversion, a threshold rewritten below the running count, and the exact cycle at which a clear write collides with a hit. They also show that a read leaves the count alone and that one timer's activity does not disturb another.

// File: rtl/tmr_pkg.sv
// Shared types and register selects for the threshold-compare timer bank.
// Assumes a word-addressed port whose low two address bits pick the register.
package tmr_pkg;
    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL   = 2'd0,
        SEL_THRESH = 2'd1,
        SEL_COUNT  = 2'd2,
        SEL_STATUS = 2'd3
    } reg_sel_e;

    // Control word, run is bit0.
    typedef struct packed {
        logic level;    // bit3: hold interrupt as level
        logic invert;   // bit2: count falling input edges
        logic oneshot;  // bit1: stop after one hit
        logic run;      // bit0: counting enabled
    } tmr_ctrl_t;

    localparam int CTRL_W = $bits(tmr_ctrl_t);
endpackage

// File: rtl/tmr_edge.sv
// Synchronises one asynchronous timer input into the system clock domain and
// emits a one-cycle strobe per active edge. The polarity select is applied
// before the synchroniser, so toggling it may itself produce one strobe.
module tmr_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    input  logic invert_i,
    output logic edge_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Shift the polarity-adjusted input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i ^ invert_i};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Active edge: synchronised level high now, low one cycle before.
    always_comb edge_o = sync_q[SYNC_STAGES-1] & ~prev_q;

    initial begin
        if (SYNC_STAGES < 2) $error("tmr_edge: SYNC_STAGES must be at least 2");
    end
endmodule

// File: rtl/tmr_unit.sv
// One timer: control, threshold, count and sticky status registers, the
// threshold compare and the interrupt output stage. Write strobes arrive
// already decoded for this timer. A hit is count+1 >= threshold on a counted
// edge, so a threshold lowered below the running count still ends the cycle.
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tclk_i,
    input  logic              wr_ctrl_i,
    input  logic              wr_thr_i,
    input  logic              wr_stat_i,
    input  logic [DATA_W-1:0] wdata_i,
    output tmr_ctrl_t         ctrl_o,
    output logic [CNT_W-1:0]  thr_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              stat_o,
    output logic              irq_o
);
    tmr_ctrl_t        ctrl_q;
    logic [CNT_W-1:0] thr_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_inc;
    logic             stat_q;
    logic             pulse_q;
    logic             tick;
    logic             step;
    logic             hit;

    tmr_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_i    (tclk_i),
        .invert_i (ctrl_q.invert),
        .edge_o   (tick)
    );

    // Compare the incremented count against the threshold on a counted edge.
    always_comb begin
        cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);
        step    = tick & ctrl_q.run;
        hit     = step & (cnt_inc >= {1'b0, thr_q});
    end

    // Control register; a software write outranks the one-shot self-stop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_ctrl_i)
            ctrl_q <= tmr_ctrl_t'(wdata_i[CTRL_W-1:0]);
        else if (hit && ctrl_q.oneshot)
            ctrl_q.run <= 1'b0;
    end

    // Threshold register, writable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)
            thr_q <= '1;
        else if (wr_thr_i)
            thr_q <= wdata_i[CNT_W-1:0];
    end

    // Counter: advance on counted edges, restart from zero on a hit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (step)
            cnt_q <= hit ? '0 : cnt_inc[CNT_W-1:0];
    end

    // Sticky status: a hit sets it and wins over a write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= 1'b0;
        else if (hit)
            stat_q <= 1'b1;
        else if (wr_stat_i && wdata_i[0])
            stat_q <= 1'b0;
    end

    // One-cycle registered copy of the hit for pulse signalling.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse_q <= 1'b0;
        else
            pulse_q <= hit;
    end

    // Interrupt form chosen per timer.
    always_comb irq_o = ctrl_q.level ? stat_q : pulse_q;

    always_comb begin
        ctrl_o = ctrl_q;
        thr_o  = thr_q;
        cnt_o  = cnt_q;
        stat_o = stat_q;
    end

    // R7: a pulse interrupt never lasts two cycles.
    p_pulse_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.level && pulse_q) |=> !pulse_q);

    // R8: level status holds until a clear write.
    p_status_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q && !(wr_stat_i && wdata_i[0])) |=> stat_q);

    // R9: a hit always leaves status set, even against a clear.
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> stat_q);

    // R5: a hit returns the count to zero.
    p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cnt_q == '0));

    // R6: a one-shot hit drops the run bit.
    p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && ctrl_q.oneshot && !wr_ctrl_i) |=> !ctrl_q.run);

    // R11: a stopped timer keeps its count.
    p_hold_stopped_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.run |=> $stable(cnt_q));

    // R3: each counted edge below threshold adds exactly one.
    p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ctrl_q.run && !hit) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/tmr_bank.sv
// Bank of threshold-compare timers behind one word-addressed register port.
// Address = {timer index, register select}; reads are combinational from the
// address, writes take effect on the clock edge where bus_wr_i is high.
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int N_TMR       = 16,
    parameter int CNT_W       = 16,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = (N_TMR > 1) ? $clog2(N_TMR) : 1,
    localparam int ADDR_W     = IDX_W + SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TMR-1:0]  tmr_clk_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic [N_TMR-1:0]  irq_o
);
    logic [IDX_W-1:0] idx;
    reg_sel_e         sel;

    tmr_ctrl_t        ctrl_a [N_TMR];
    logic [CNT_W-1:0] thr_a  [N_TMR];
    logic [CNT_W-1:0] cnt_a  [N_TMR];
    logic [N_TMR-1:0] stat_a;

    // Split the word address into timer index and register select.
    always_comb begin
        idx = bus_addr_i[ADDR_W-1:SEL_W];
        sel = reg_sel_e'(bus_addr_i[SEL_W-1:0]);
    end

    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
        logic me;
        always_comb me = bus_wr_i && (idx == IDX_W'(g));

        tmr_unit #(
            .CNT_W       (CNT_W),
            .DATA_W      (DATA_W),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_unit (
            .clk       (clk),
            .rst_n     (rst_n),
            .tclk_i    (tmr_clk_i[g]),
            .wr_ctrl_i (me && sel == SEL_CTRL),
            .wr_thr_i  (me && sel == SEL_THRESH),
            .wr_stat_i (me && sel == SEL_STATUS),
            .wdata_i   (bus_wdata_i),
            .ctrl_o    (ctrl_a[g]),
            .thr_o     (thr_a[g]),
            .cnt_o     (cnt_a[g]),
            .stat_o    (stat_a[g]),
            .irq_o     (irq_o[g])
        );
    end

    // Read multiplexer; absent timers and unused bits read zero.
    always_comb begin
        bus_rdata_o = '0;
        if (int'(idx) < N_TMR) begin
            case (sel)
                SEL_CTRL:   bus_rdata_o[CTRL_W-1:0] = ctrl_a[idx];
                SEL_THRESH: bus_rdata_o[CNT_W-1:0]  = thr_a[idx];
                SEL_COUNT:  bus_rdata_o[CNT_W-1:0]  = cnt_a[idx];
                default:    bus_rdata_o[0]          = stat_a[idx];
            endcase
        end
    end

    // R1: no interrupt is raised in the cycle after reset.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (irq_o == '0));
endmodule

// File: tb/test_tmr_bank.sv
module test_tmr_bank;
    localparam int N  = 16;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  tclk = '0;
    logic          wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [N-1:0]  irq;

    typedef struct {
        logic [31:0] v;
        string       tag;
    } item_t;

    item_t exp_q[$];
    item_t act_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    always #2 clk = ~clk;

    tmr_bank i_tmr_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .tmr_clk_i   (tclk),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    // Monitor: pairs expected and observed items in order.
    initial begin
        forever begin
            @(posedge clk);
            while (exp_q.size() > 0 && act_q.size() > 0) begin
                item_t e;
                item_t a;
                e = exp_q.pop_front();
                a = act_q.pop_front();
                n_cmp++;
                if (a.v !== e.v) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", e.tag, a.v, e.v);
                end
            end
        end
    end

    task automatic push(input logic [31:0] act, input logic [31:0] exp, input string tag);
        item_t e;
        item_t a;
        e.v = exp; e.tag = tag;
        a.v = act; a.tag = tag;
        exp_q.push_back(e);
        act_q.push_back(a);
    endtask

    task automatic wreg(input int t, input int s, input logic [31:0] d);
        addr  = AW'((t << 2) | s);
        wdata = d;
        wr    = 1'b1;
        @(negedge clk);
        wr    = 1'b0;
    endtask

    task automatic rchk(input int t, input int s, input logic [31:0] exp, input string tag);
        addr = AW'((t << 2) | s);
        #1;
        push(rdata, exp, tag);
        @(negedge clk);
    endtask

    // One full input pulse; counts the cycles irq of that timer was high.
    task automatic pulse(input int t, output int hi);
        hi = 0;
        tclk[t] = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (irq[t]) hi++;
        end
        tclk[t] = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (irq[t]) hi++;
        end
    endtask

    task automatic pulses(input int t, input int n);
        int h;
        for (int k = 0; k < n; k++) pulse(t, h);
    endtask

    task automatic finish_run();
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int h;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rchk(0, 0, 32'h0, "R1 ctrl");
        rchk(0, 1, 32'hFFFF, "R1 threshold");
        rchk(9, 2, 32'h0, "R1 count");
        rchk(9, 3, 32'h0, "R1 status");
        push(32'(irq), 32'h0, "R1 irq");

        // Timer 0: cyclic, pulse form, threshold 3
        wreg(0, 1, 32'd3);
        rchk(0, 1, 32'd3, "R2 threshold readback");
        wreg(0, 0, 32'h1);
        pulses(0, 2);
        rchk(0, 2, 32'd2, "R3 count after two edges");
        pulse(0, h);
        push(32'(h), 32'd1, "R7 one-cycle pulse on hit");
        rchk(0, 2, 32'd0, "R5 count wraps to zero");
        rchk(0, 3, 32'd1, "R5 status set");
        rchk(0, 0, 32'h1, "R5 cyclic keeps running");
        push(32'(irq[0]), 32'd0, "R7 pulse low while status set");
        pulses(0, 2);
        pulse(0, h);
        push(32'(h), 32'd1, "R5 second cyclic hit");
        pulse(0, h);
        rchk(0, 2, 32'd1, "R5 counting continues");

        // Timer 1: level form, threshold 2
        wreg(1, 1, 32'd2);
        wreg(1, 0, 32'h9);
        pulses(1, 2);
        push(32'(irq[1]), 32'd1, "R8 level irq raised");
        repeat (10) @(negedge clk);
        push(32'(irq[1]), 32'd1, "R8 level irq held");
        wreg(1, 3, 32'h0);
        push(32'(irq[1]), 32'd1, "R8 write of zero ignored");
        wreg(1, 3, 32'h1);
        push(32'(irq[1]), 32'd0, "R8 write-one clear");
        rchk(0, 2, 32'd1, "R12 timer0 count untouched");
        rchk(0, 3, 32'd1, "R12 timer0 status untouched");

        // Timer 2: one-shot, threshold 2
        wreg(2, 1, 32'd2);
        wreg(2, 0, 32'h3);
        pulses(2, 2);
        rchk(2, 0, 32'h2, "R6 run bit cleared");
        rchk(2, 3, 32'd1, "R6 status set");
        pulses(2, 2);
        rchk(2, 2, 32'd0, "R6 stopped at zero");

        // Timer 3: inverted input, counts falling edges
        wreg(3, 1, 32'd5);
        wreg(3, 0, 32'h4);
        repeat (6) @(negedge clk);
        wreg(3, 0, 32'h5);
        repeat (6) @(negedge clk);
        rchk(3, 2, 32'd0, "R4 no count on polarity setup");
        tclk[3] = 1'b1;
        repeat (6) @(negedge clk);
        rchk(3, 2, 32'd0, "R4 rising edge ignored");
        tclk[3] = 1'b0;
        repeat (6) @(negedge clk);
        rchk(3, 2, 32'd1, "R4 falling edge counted");

        // Timer 4: threshold raised-range rewrite while running
        wreg(4, 1, 32'd10);
        wreg(4, 0, 32'h1);
        pulses(4, 4);
        wreg(4, 1, 32'd6);
        pulse(4, h);
        rchk(4, 2, 32'd5, "R10 count below new threshold");
        pulse(4, h);
        rchk(4, 2, 32'd0, "R10 hit at new threshold");
        rchk(4, 3, 32'd1, "R10 status on new threshold");

        // Timer 5: threshold rewritten below the running count
        wreg(5, 1, 32'd10);
        wreg(5, 0, 32'h1);
        pulses(5, 5);
        wreg(5, 1, 32'd3);
        rchk(5, 3, 32'd0, "R10 no hit before next edge");
        pulse(5, h);
        rchk(5, 2, 32'd0, "R10 lowered threshold hit");
        rchk(5, 3, 32'd1, "R10 lowered threshold status");

        // Timer 6: hold on stop, reads do not disturb
        wreg(6, 1, 32'd10);
        wreg(6, 0, 32'h1);
        pulses(6, 3);
        rchk(6, 2, 32'd3, "R11 read one");
        rchk(6, 2, 32'd3, "R11 read two");
        rchk(6, 2, 32'd3, "R11 read three");
        wreg(6, 0, 32'h0);
        pulses(6, 2);
        rchk(6, 2, 32'd3, "R11 count held while stopped");
        wreg(6, 0, 32'h1);
        pulse(6, h);
        rchk(6, 2, 32'd4, "R11 resumes from held value");

        // Timer 7: clear write colliding with a hit
        wreg(7, 1, 32'd1);
        wreg(7, 0, 32'h9);
        pulse(7, h);
        rchk(7, 3, 32'd1, "R9 first hit");
        tclk[7] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        addr  = AW'((7 << 2) | 3);
        wdata = 32'h1;
        wr    = 1'b1;
        @(negedge clk);
        wr    = 1'b0;
        rchk(7, 3, 32'd1, "R9 hit wins over clear");
        push(32'(irq[7]), 32'd1, "R9 level irq stays high");
        tclk[7] = 1'b0;
        repeat (6) @(negedge clk);
        wreg(7, 3, 32'h1);
        rchk(7, 3, 32'd0, "R8 later clear succeeds");
        rchk(8, 2, 32'd0, "R12 idle timer count");
        rchk(8, 3, 32'd0, "R12 idle timer status");

        finish_run();
    end
endmodule